// File: doc/BRIEF.md
# PLL Rate-to-Divider Configuration Calculator

This block turns a requested serial line rate, given in Hz, into the settings a display transmit PHY needs for its PLL: a power-of-two transmit post-divider, encoded as two 2-bit sub-codes, and a 31-bit fixed-point frequency control word. A one-cycle start pulse launches the work. The rate is first limited to the supported band, then a range decode picks the divide factor N. A sequential shift-subtract divider then computes the control word against a fixed 26 MHz reference, producing one quotient bit per clock.

The control word is floor(rate × 2 × N × 2^24 / 26,000,000). Bits 30..24 of the word carry its integer part and bits 23..0 carry its fraction. A rate that cannot be served raises an error flag on the completion strobe and leaves the previous configuration in place. The surrounding control logic raises start, waits for the done strobe, and then copies the codes and the word into the PHY's registers.

Top module: `pll_rate_cfg`

## Requirements
- R1: A requested rate above 1,250,000,000 Hz is treated as exactly 1,250,000,000 Hz, whatever the value of clamp_low.
- R2: When clamp_low is 1, a requested rate below 50,000,000 Hz is treated as exactly 50,000,000 Hz.
- R3: Rates of at least 500,000,000 Hz give N=1 with div0_code=0 and div1_code=0. Rates of at least 250,000,000 Hz but below 500,000,000 Hz give N=2 with div0_code=1 and div1_code=0. Rates of at least 125,000,000 Hz but below 250,000,000 Hz give N=4 with div0_code=2 and div1_code=0.
- R4: Rates strictly above 62,000,000 Hz and below 125,000,000 Hz give N=8 with div0_code=2 and div1_code=1. Rates from 50,000,000 Hz to 62,000,000 Hz inclusive give N=16 with div0_code=2 and div1_code=2.
- R5: When clamp_low is 0 and the rate is below 50,000,000 Hz, done pulses on the edge that accepts start, with err=1. In this case div0_code, div1_code and ctrl_word keep their previous values.
- R6: After a valid computation, ctrl_word equals floor(rate × 2 × N × 2^24 / 26,000,000), using the limited rate. Its integer field, bits 30..24, never exceeds 96.
- R7: For a valid rate, done is high for exactly one cycle and rises on the 64th clock edge after the edge that accepts start. busy is high in between. err is 0 on that completion.
- R8: A start pulse that arrives while busy is 1 is ignored, and the computation in flight completes with its own result.
- R9: After reset, all outputs are 0. div0_code, div1_code and ctrl_word change only on a cycle where done is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| clamp_low | input | 1 | 1: raise low rates to the floor; 0: flag them as errors |
| rate_hz | input | 32 | Requested line rate in Hz |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last completion rejected the rate |
| div0_code | output | 2 | First post-divider sub-code |
| div1_code | output | 2 | Second post-divider sub-code |
| ctrl_word | output | 31 | PLL control word, 7.24 fixed point |

## Verification
The embedded properties check on every cycle that done never lasts two cycles, that the published codes and word move only with done, that the codes always form one of the five legal pairs, and that the integer field stays within its bound. A rejected rate must also leave busy low and the word untouched. Only the bench's scenarios can show that each threshold lands on the correct side, that the word matches the exact 64-bit quotient, that both limiting rules act, that the latency is 64 cycles, and that a second start during a run is ignored.

// File: rtl/pll_rate_cfg.sv
module pll_rate_cfg #(
  parameter int RATE_W = 32,
  parameter int DVD_W  = 64,
  parameter int FRAC_W = 24,
  parameter int WORD_W = 31,
  parameter int REF_HZ = 26_000_000,
  parameter int MIN_HZ = 50_000_000,
  parameter int MAX_HZ = 1_250_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clamp_low,
  input  logic [31:0]       rate_hz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        div0_code,
  output logic [1:0]        div1_code,
  output logic [WORD_W-1:0] ctrl_word
);

  localparam int REM_W = $clog2(REF_HZ);
  localparam int CNT_W = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);
  localparam logic [REM_W:0]   REF_V = (REM_W+1)'(REF_HZ);
  localparam logic [31:0] LO_V  = 32'(MIN_HZ);
  localparam logic [31:0] HI_V  = 32'(MAX_HZ);
  localparam logic [31:0] T_D1  = 32'd500_000_000;
  localparam logic [31:0] T_D2  = 32'd250_000_000;
  localparam logic [31:0] T_D4  = 32'd125_000_000;
  localparam logic [31:0] T_D8  = 32'd62_000_000;

  logic [31:0]       rate_c;
  logic [2:0]        k, k_q;
  logic              bad;
  logic [6:0]        shamt;
  logic [DVD_W-1:0]  load, dvd, dvd_n;
  logic [REM_W-1:0]  rem, rem_n;
  logic [REM_W:0]    rem_sh, rem_dif;
  logic              ge;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        c0, c1;

  assign rate_c = (rate_hz > HI_V)                ? HI_V :
                  (clamp_low && rate_hz < LO_V)  ? LO_V : rate_hz;

  assign bad = rate_c < LO_V;
  assign k   = (rate_c >= T_D1) ? 3'd0 :
               (rate_c >= T_D2) ? 3'd1 :
               (rate_c >= T_D4) ? 3'd2 :
               (rate_c >  T_D8) ? 3'd3 : 3'd4;

  assign shamt = 7'(FRAC_W + 1) + 7'(k);
  assign load  = {{(DVD_W-32){1'b0}}, rate_c} << shamt;

  assign rem_sh  = {rem, dvd[DVD_W-1]};
  assign ge      = rem_sh >= REF_V;
  assign rem_dif = rem_sh - REF_V;
  assign rem_n   = ge ? rem_dif[REM_W-1:0] : rem_sh[REM_W-1:0];
  assign dvd_n   = {dvd[DVD_W-2:0], ge};

  assign c0 = (k_q == 3'd0) ? 2'd0 : (k_q == 3'd1) ? 2'd1 : 2'd2;
  assign c1 = (k_q == 3'd3) ? 2'd1 : (k_q == 3'd4) ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      div0_code <= '0; div1_code <= '0; ctrl_word <= '0;
      dvd <= '0; rem <= '0; cnt <= '0; k_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (bad) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            busy <= 1'b1;
            dvd  <= load;
            rem  <= '0;
            cnt  <= '0;
            k_q  <= k;
          end
        end
      end else begin
        dvd <= dvd_n;
        rem <= rem_n;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          err       <= 1'b0;
          ctrl_word <= dvd_n[WORD_W-1:0];
          div0_code <= c0;
          div1_code <= c1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(busy));                                  // R7
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({div0_code, div1_code, ctrl_word}));            // R9
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (!busy && $stable(ctrl_word)));                 // R5
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (div0_code != 2'd3) && (div1_code != 2'd3) &&
    ((div1_code == 2'd0) || (div0_code == 2'd2)));                    // R4
  AST_INT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (ctrl_word[WORD_W-1:FRAC_W] <= (WORD_W-FRAC_W)'(96))); // R6

endmodule

// File: tb/pll_rate_cfg_tb.sv
module pll_rate_cfg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clamp_low = 1'b0;
  logic [31:0] rate_hz = '0;
  logic busy, done, err;
  logic [1:0] div0_code, div1_code;
  logic [30:0] ctrl_word;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0]  prev_c0 = '0, prev_c1 = '0;
  logic [30:0] prev_w = '0;

  always #5 clk = ~clk;

  pll_rate_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clamp_low(clamp_low),
    .rate_hz(rate_hz), .busy(busy), .done(done), .err(err),
    .div0_code(div0_code), .div1_code(div1_code), .ctrl_word(ctrl_word)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1 R2 R3 R4 reference: limiting, decode and 64-bit quotient
  task automatic model(input longint unsigned r, input bit cl, output bit e,
                       output logic [1:0] c0, output logic [1:0] c1, output logic [30:0] w);
    longint unsigned rc, n;
    rc = r;
    if (rc > 64'd1250000000) rc = 64'd1250000000;
    if (cl && rc < 64'd50000000) rc = 64'd50000000;
    e = rc < 64'd50000000;
    if (rc >= 64'd500000000)      begin n = 1;  c0 = 2'd0; c1 = 2'd0; end
    else if (rc >= 64'd250000000) begin n = 2;  c0 = 2'd1; c1 = 2'd0; end
    else if (rc >= 64'd125000000) begin n = 4;  c0 = 2'd2; c1 = 2'd0; end
    else if (rc > 64'd62000000)   begin n = 8;  c0 = 2'd2; c1 = 2'd1; end
    else                          begin n = 16; c0 = 2'd2; c1 = 2'd2; end
    w = 31'(((rc * 2 * n) << 24) / 64'd26000000);
  endtask

  task automatic run(input logic [31:0] r, input bit cl, input bit poke);
    bit e; logic [1:0] c0, c1; logic [30:0] w; int lat;
    model(r, cl, e, c0, c1, w);
    @(negedge clk);
    rate_hz = r; clamp_low = cl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      if (poke && lat == 10) begin start = 1'b1; rate_hz = r ^ 32'h0123_4567; clamp_low = 1'b1; end
      else start = 1'b0;
      if (lat == 20) chk(busy === (poke ? 1'b1 : 1'b1), "R7 busy mid-run", busy, 1);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (e) begin
      chk(lat == 0, "R5 error latency", lat, 0);
      chk(err === 1'b1, "R5 err flag", err, 1);
      chk(ctrl_word === prev_w, "R5 word kept", ctrl_word, prev_w);
      chk(div0_code === prev_c0 && div1_code === prev_c1, "R5 codes kept",
          {div0_code, div1_code}, {prev_c0, prev_c1});
    end else begin
      chk(lat == 64, poke ? "R8 latency with ignored start" : "R7 latency", lat, 64);
      chk(err === 1'b0, "R7 err clear", err, 0);
      chk(div0_code === c0, "R3 R4 div0_code", div0_code, c0);
      chk(div1_code === c1, "R3 R4 div1_code", div1_code, c1);
      chk(ctrl_word === w, poke ? "R8 word unaffected" : "R6 ctrl_word", ctrl_word, w);
      prev_w = w; prev_c0 = c0; prev_c1 = c1;
    end
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", done, 0);
    chk(ctrl_word === prev_w, "R9 hold after done", ctrl_word, prev_w);
  endtask

  initial begin
    #200000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && div0_code == 0 && div1_code == 0 && ctrl_word == 0,
        "R9 reset state", {busy, done, err, div0_code, div1_code}, 0);

    // R3 R4 thresholds
    run(32'd50000000, 1'b0, 1'b0);
    run(32'd62000000, 1'b0, 1'b0);
    run(32'd62000001, 1'b0, 1'b0);
    run(32'd124999999, 1'b0, 1'b0);
    run(32'd125000000, 1'b0, 1'b0);
    run(32'd249999999, 1'b0, 1'b0);
    run(32'd250000000, 1'b0, 1'b0);
    run(32'd499999999, 1'b0, 1'b0);
    run(32'd500000000, 1'b0, 1'b0);
    run(32'd1250000000, 1'b0, 1'b0);
    // R1 upper limit
    run(32'd1250000001, 1'b0, 1'b0);
    run(32'hFFFF_FFFF, 1'b1, 1'b0);
    // R5 rejection, then R2 raising
    run(32'd49999999, 1'b0, 1'b0);
    run(32'd0, 1'b0, 1'b0);
    run(32'd10000000, 1'b1, 1'b0);
    run(32'd49999999, 1'b1, 1'b0);
    // R8 start while busy
    run(32'd333000000, 1'b0, 1'b1);
    run(32'd70000000, 1'b0, 1'b1);
    // R6 sweep across the band
    for (longint unsigned r = 40000000; r <= 1300000000; r += 9876543)
      run(32'(r), r[0], 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule